// File: doc/BRIEF.md
# Circular Instruction Prefetch Buffer Set

This block sits beside a small instruction cache and keeps a ring of NBUF prefetch buffers, each holding LINES consecutive cache lines. Each executed branch claims the next buffer in the ring and fills it from a predicted target address supplied by an external predictor. Line requests go to a second-level cache through a tagged request/response interface with a fixed latency. When the sequential mode is enabled, a cache miss also claims a buffer and fills the lines after the missing line. That sequential fill stops at the next branch or the next miss.

The fetch stage probes every buffer in the same cycle as it probes the cache. The block picks one of NBUF+1 sources: the cache, or one of the buffers. It returns that line together with a source code.

Top module: `ibr_prefetch_ring`

## Requirements
- R1: After reset every buffer is empty, no L2 request is raised, a fetch probe with no cache hit returns out_valid low, and the first allocation goes to buffer 0.
- R2: Allocations (branches, plus sequential-mode misses) take buffers in strict ring order. The n-th allocation since reset uses buffer n mod NBUF. Taking a buffer discards whatever lines it held.
- R3: A branch with target T loads lines T..T+LINES-1 into the claimed buffer, and one L2 request is raised for each of those lines. Request tags are packed as {buffer index, slot index, generation}, with the generation in the least significant GEN_W bits. The generation is the number of times that buffer has been allocated, modulo 2^GEN_W.
- R4: At most one L2 request is raised per cycle. The buffer whose allocation is oldest goes first, and within a buffer the lower slot goes first. Requests appear from the cycle after the allocation edge. No request is raised for a line that is not waiting.
- R5: A line answers a fetch probe only after its L2 response has been captured. A probe of an allocated but still pending line reports a miss, and out_valid stays low while fetch_valid is low.
- R6: The fetch result is combinational in the probe cycle. A cache hit wins, with out_src 0 and the cache's data. Otherwise a buffer hit gives out_src equal to buffer index plus 1 and the buffer's data.
- R7: When several buffers hold the probed line, the most recently allocated of them supplies it.
- R8: A response whose generation differs from the buffer's current generation is dropped and never becomes visible.
- R9: With seq_en high, a miss (without a branch in the same cycle) claims the next buffer and loads lines M+1..M+LINES. With seq_en low, a miss allocates nothing.
- R10: A branch or a miss cancels every line of a sequential-mode buffer that has not yet been requested. Cancelled lines are never requested and never hit. A line requested on that same edge still completes.
- R11: When a branch and a miss coincide, only the branch allocates a buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| br_valid | input | 1 | A branch executed this cycle |
| br_target | input | AW | Predicted line address to prefetch from |
| seq_en | input | 1 | Enables sequential prefetch on cache misses |
| miss_valid | input | 1 | Instruction cache missed this cycle |
| miss_addr | input | AW | Line address that missed |
| fetch_valid | input | 1 | Fetch probe this cycle |
| fetch_addr | input | AW | Line address being fetched |
| cache_hit | input | 1 | Cache hit for the same probe |
| cache_data | input | DW | Cache line data for the probe |
| out_valid | output | 1 | Line returned from any source |
| out_data | output | DW | Selected line data |
| out_src | output | SRCW | 0 = cache, k = buffer k-1 |
| l2_req_valid | output | 1 | L2 line request |
| l2_req_addr | output | AW | Requested line address |
| l2_req_tag | output | TAG_W | {buffer, slot, generation} |
| l2_rsp_valid | input | 1 | L2 response |
| l2_rsp_tag | input | TAG_W | Tag echoed from the request |
| l2_rsp_data | input | DW | Returned line data |

## Verification
The assertions check the following on every cycle:
- the ring pointer advances on an allocation and holds otherwise;
- every request carries the current generation of a buffer that exists;
- a cache hit always takes the output;
- a buffer-sourced output never appears without a probe.

Only the bench scenarios can show the following:
- the exact request order across back-to-back allocations;
- stale responses being dropped after a reallocation;
- the youngest-copy priority;
- the cancellation of unrequested sequential lines;
- the precedence of a branch over a coincident miss.

These are checked through an ordered request scoreboard and through probes timed against the fixed response latency.

// File: rtl/ibr_pkg.sv
// Shared types for the circular prefetch buffer set.
package ibr_pkg;
    // Life cycle of one line slot inside a buffer.
    typedef enum logic [1:0] {
        SL_EMPTY = 2'd0,
        SL_WAIT  = 2'd1,
        SL_PEND  = 2'd2,
        SL_VALID = 2'd3
    } slot_st_e;
endpackage

// File: rtl/ibr_buffer.sv
// One prefetch buffer of LINES consecutive lines.
// Does: loads a base address on allocation, reports its lowest waiting
// slot for request arbitration, takes responses that match its current
// generation, and answers associative probes from completed lines.
// Assumes: allocation overrides issue, response and cancel in the same cycle;
// the caller decodes which responses belong to this buffer.
module ibr_buffer
    import ibr_pkg::*;
#(
    parameter int LINES = 2,
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int GEN_W = 2,
    localparam int SW   = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc,
    input  logic [AW-1:0]    alloc_base,
    input  logic             alloc_seq,
    input  logic             seq_stop,
    input  logic             issue,
    input  logic             rsp_we,
    input  logic [SW-1:0]    rsp_slot,
    input  logic [GEN_W-1:0] rsp_gen,
    input  logic [DW-1:0]    rsp_data,
    input  logic [AW-1:0]    lk_addr,
    output logic [GEN_W-1:0] gen_q,
    output logic             wait_any,
    output logic [SW-1:0]    wait_slot,
    output logic [AW-1:0]    wait_addr,
    output logic             lk_hit,
    output logic [DW-1:0]    lk_data
);
    slot_st_e        st_q   [LINES];
    logic [AW-1:0]   addr_q [LINES];
    logic [DW-1:0]   data_q [LINES];
    logic            seq_q;

    // Find the lowest slot still waiting for a request.
    always_comb begin
        wait_any  = 1'b0;
        wait_slot = '0;
        wait_addr = '0;
        for (int s = LINES - 1; s >= 0; s--) begin
            if (st_q[s] == SL_WAIT) begin
                wait_any  = 1'b1;
                wait_slot = SW'(s);
                wait_addr = addr_q[s];
            end
        end
    end

    // Associative probe over completed lines only.
    always_comb begin
        lk_hit  = 1'b0;
        lk_data = '0;
        for (int s = LINES - 1; s >= 0; s--) begin
            if (st_q[s] == SL_VALID && addr_q[s] == lk_addr) begin
                lk_hit  = 1'b1;
                lk_data = data_q[s];
            end
        end
    end

    // Slot state, addresses, data and generation bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gen_q <= '0;
            seq_q <= 1'b0;
            for (int s = 0; s < LINES; s++) begin
                st_q[s]   <= SL_EMPTY;
                addr_q[s] <= '0;
                data_q[s] <= '0;
            end
        end else if (alloc) begin
            gen_q <= gen_q + GEN_W'(1);
            seq_q <= alloc_seq;
            for (int s = 0; s < LINES; s++) begin
                st_q[s]   <= SL_WAIT;
                addr_q[s] <= alloc_base + AW'(s);
            end
        end else begin
            if (seq_stop) begin
                seq_q <= 1'b0;
            end
            for (int s = 0; s < LINES; s++) begin
                if (issue && wait_any && wait_slot == SW'(s)) begin
                    st_q[s] <= SL_PEND;
                end else if (seq_stop && seq_q && st_q[s] == SL_WAIT) begin
                    st_q[s] <= SL_EMPTY;
                end else if (rsp_we && rsp_gen == gen_q && rsp_slot == SW'(s)
                             && st_q[s] == SL_PEND) begin
                    st_q[s]   <= SL_VALID;
                    data_q[s] <= rsp_data;
                end
            end
        end
    end
endmodule

// File: rtl/ibr_req_arb.sv
// Picks the one buffer allowed to send an L2 request this cycle.
// Does: scans from the ring pointer (the oldest allocation) forward and
// grants the first buffer with a waiting line.
// Assumes: ptr always holds a value below NBUF.
module ibr_req_arb #(
    parameter int NBUF = 3,
    localparam int BW  = (NBUF > 1) ? $clog2(NBUF) : 1
) (
    input  logic [NBUF-1:0] wait_any,
    input  logic [BW-1:0]   ptr,
    output logic            grant_vld,
    output logic [BW-1:0]   grant_idx,
    output logic [NBUF-1:0] grant_oh
);
    // Oldest-first search; the last assignment in the loop wins.
    always_comb begin
        int idx;
        grant_vld = 1'b0;
        grant_idx = '0;
        grant_oh  = '0;
        for (int d = NBUF - 1; d >= 0; d--) begin
            idx = (int'(ptr) + d) % NBUF;
            if (wait_any[idx]) begin
                grant_vld = 1'b1;
                grant_idx = BW'(idx);
            end
        end
        for (int b = 0; b < NBUF; b++) begin
            grant_oh[b] = grant_vld && (grant_idx == BW'(b));
        end
    end
endmodule

// File: rtl/ibr_hit_sel.sv
// Chooses among NBUF+1 line sources for a fetch probe.
// Does: the cache has first claim; among buffer hits the youngest
// allocation wins.
// Assumes: ptr names the next buffer to allocate, so ptr-1 is the youngest.
module ibr_hit_sel #(
    parameter int NBUF = 3,
    parameter int DW   = 32,
    localparam int BW  = (NBUF > 1) ? $clog2(NBUF) : 1,
    localparam int SRCW = $clog2(NBUF + 1)
) (
    input  logic            cache_hit,
    input  logic [DW-1:0]   cache_data,
    input  logic [NBUF-1:0] buf_hit,
    input  logic [DW-1:0]   buf_data [NBUF],
    input  logic [BW-1:0]   ptr,
    output logic            out_valid,
    output logic [DW-1:0]   out_data,
    output logic [SRCW-1:0] out_src
);
    // Scan oldest to youngest so the youngest hit overrides.
    always_comb begin
        int idx;
        out_valid = 1'b0;
        out_data  = '0;
        out_src   = '0;
        for (int d = NBUF; d >= 1; d--) begin
            idx = (int'(ptr) + NBUF - d) % NBUF;
            if (buf_hit[idx]) begin
                out_valid = 1'b1;
                out_data  = buf_data[idx];
                out_src   = SRCW'(idx + 1);
            end
        end
        if (cache_hit) begin
            out_valid = 1'b1;
            out_data  = cache_data;
            out_src   = '0;
        end
    end
endmodule

// File: rtl/ibr_prefetch_ring.sv
// Top of the circular prefetch buffer set.
// Does: allocates buffers in ring order on branches (and on misses in
// sequential mode), sends tagged line requests to the L2 one per cycle,
// steers responses to buffers by tag, and selects the fetch result.
// Assumes: the L2 accepts every request raised and echoes its tag.
module ibr_prefetch_ring
    import ibr_pkg::*;
#(
    parameter int NBUF  = 3,
    parameter int LINES = 2,
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int GEN_W = 2,
    localparam int BW    = (NBUF > 1) ? $clog2(NBUF) : 1,
    localparam int SW    = (LINES > 1) ? $clog2(LINES) : 1,
    localparam int TAG_W = BW + SW + GEN_W,
    localparam int SRCW  = $clog2(NBUF + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             br_valid,
    input  logic [AW-1:0]    br_target,
    input  logic             seq_en,
    input  logic             miss_valid,
    input  logic [AW-1:0]    miss_addr,
    input  logic             fetch_valid,
    input  logic [AW-1:0]    fetch_addr,
    input  logic             cache_hit,
    input  logic [DW-1:0]    cache_data,
    output logic             out_valid,
    output logic [DW-1:0]    out_data,
    output logic [SRCW-1:0]  out_src,
    output logic             l2_req_valid,
    output logic [AW-1:0]    l2_req_addr,
    output logic [TAG_W-1:0] l2_req_tag,
    input  logic             l2_rsp_valid,
    input  logic [TAG_W-1:0] l2_rsp_tag,
    input  logic [DW-1:0]    l2_rsp_data
);
    logic [BW-1:0]        ptr_q;
    logic                 seq_alloc, alloc_any, seq_stop;
    logic [AW-1:0]        alloc_base;
    logic [BW-1:0]        rsp_buf;
    logic [SW-1:0]        rsp_slot;
    logic [GEN_W-1:0]     rsp_gen;
    logic [GEN_W-1:0]     gen_arr  [NBUF];
    logic [SW-1:0]        wslot    [NBUF];
    logic [AW-1:0]        waddr    [NBUF];
    logic [DW-1:0]        hdata    [NBUF];
    logic [NBUF-1:0]      wait_any, buf_hit, grant_oh;
    logic                 grant_vld;
    logic [BW-1:0]        grant_idx;
    logic [NBUF*GEN_W-1:0] gen_flat;
    logic [SW-1:0]        req_slot;
    logic [GEN_W-1:0]     req_gen;

    // Allocation and cancel decisions; a branch outranks a miss.
    assign seq_alloc  = seq_en && miss_valid && !br_valid;
    assign alloc_any  = br_valid || seq_alloc;
    assign seq_stop   = br_valid || miss_valid;
    assign alloc_base = br_valid ? br_target : (miss_addr + AW'(1));

    // Response tag fields.
    assign rsp_buf  = l2_rsp_tag[TAG_W-1 -: BW];
    assign rsp_slot = l2_rsp_tag[GEN_W +: SW];
    assign rsp_gen  = l2_rsp_tag[GEN_W-1:0];

    // Ring pointer: next buffer to allocate, also the oldest allocation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (alloc_any) begin
            ptr_q <= (ptr_q == BW'(NBUF - 1)) ? '0 : ptr_q + BW'(1);
        end
    end

    for (genvar i = 0; i < NBUF; i++) begin : g_buf
        ibr_buffer #(
            .LINES(LINES), .AW(AW), .DW(DW), .GEN_W(GEN_W)
        ) u_buf (
            .clk        (clk),
            .rst_n      (rst_n),
            .alloc      (alloc_any && ptr_q == BW'(i)),
            .alloc_base (alloc_base),
            .alloc_seq  (seq_alloc),
            .seq_stop   (seq_stop),
            .issue      (grant_oh[i]),
            .rsp_we     (l2_rsp_valid && rsp_buf == BW'(i)),
            .rsp_slot   (rsp_slot),
            .rsp_gen    (rsp_gen),
            .rsp_data   (l2_rsp_data),
            .lk_addr    (fetch_addr),
            .gen_q      (gen_arr[i]),
            .wait_any   (wait_any[i]),
            .wait_slot  (wslot[i]),
            .wait_addr  (waddr[i]),
            .lk_hit     (buf_hit[i]),
            .lk_data    (hdata[i])
        );
        assign gen_flat[i*GEN_W +: GEN_W] = gen_arr[i];
    end

    ibr_req_arb #(.NBUF(NBUF)) u_arb (
        .wait_any  (wait_any),
        .ptr       (ptr_q),
        .grant_vld (grant_vld),
        .grant_idx (grant_idx),
        .grant_oh  (grant_oh)
    );

    // Route the granted buffer's waiting line onto the request port.
    always_comb begin
        l2_req_addr = '0;
        req_slot    = '0;
        req_gen     = '0;
        for (int b = 0; b < NBUF; b++) begin
            if (grant_oh[b]) begin
                l2_req_addr = waddr[b];
                req_slot    = wslot[b];
                req_gen     = gen_arr[b];
            end
        end
    end

    assign l2_req_valid = grant_vld;
    assign l2_req_tag   = {grant_idx, req_slot, req_gen};

    ibr_hit_sel #(.NBUF(NBUF), .DW(DW)) u_sel (
        .cache_hit  (fetch_valid && cache_hit),
        .cache_data (cache_data),
        .buf_hit    (buf_hit & {NBUF{fetch_valid}}),
        .buf_data   (hdata),
        .ptr        (ptr_q),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_src    (out_src)
    );
endmodule

// File: rtl/ibr_checker.sv
// Cycle-by-cycle properties of the prefetch buffer set, bound to the top.
// Assumes: ptr_q and gen_flat are the top's ring pointer and packed
// per-buffer generations.
module ibr_checker #(
    parameter int NBUF  = 3,
    parameter int DW    = 32,
    parameter int BW    = 2,
    parameter int SW    = 1,
    parameter int GEN_W = 2,
    parameter int SRCW  = 2,
    localparam int TAG_W = BW + SW + GEN_W
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  br_valid,
    input logic                  miss_valid,
    input logic                  seq_en,
    input logic                  fetch_valid,
    input logic                  cache_hit,
    input logic [DW-1:0]         cache_data,
    input logic                  out_valid,
    input logic [DW-1:0]         out_data,
    input logic [SRCW-1:0]       out_src,
    input logic                  l2_req_valid,
    input logic [TAG_W-1:0]      l2_req_tag,
    input logic [BW-1:0]         ptr_q,
    input logic [NBUF*GEN_W-1:0] gen_flat
);
    logic [BW-1:0] req_buf;
    assign req_buf = l2_req_tag[TAG_W-1 -: BW];

    // R1: nothing is requested right after reset.
    p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !l2_req_valid);

    // R2: the ring pointer moves by one on each allocation.
    p_ptr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid || (seq_en && miss_valid)) |=>
        (ptr_q == (($past(ptr_q) == BW'(NBUF - 1)) ? '0 : $past(ptr_q) + BW'(1))));

    // R2: the ring pointer holds when nothing is allocated.
    p_ptr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(br_valid || (seq_en && miss_valid)) |=> $stable(ptr_q));

    // R3: a request names an existing buffer.
    p_req_buf_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        l2_req_valid |-> (int'(req_buf) < NBUF));

    // R8: a request carries the current generation of its buffer.
    p_req_gen_current_r8: assert property (@(posedge clk) disable iff (!rst_n)
        l2_req_valid |->
        (l2_req_tag[GEN_W-1:0] == gen_flat[int'(req_buf)*GEN_W +: GEN_W]));

    // R6: a cache hit always supplies the output.
    p_cache_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && cache_hit) |->
        (out_valid && out_src == '0 && out_data == cache_data));

    // R5: a buffer-sourced output needs a probe and a real buffer number.
    p_buf_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !cache_hit) |->
        (fetch_valid && out_src != '0 && out_src <= SRCW'(NBUF)));

    // R5: no output without a probe.
    p_no_probe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |-> !out_valid);
endmodule

bind ibr_prefetch_ring ibr_checker #(
    .NBUF(NBUF), .DW(DW), .BW(BW), .SW(SW), .GEN_W(GEN_W), .SRCW(SRCW)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .br_valid     (br_valid),
    .miss_valid   (miss_valid),
    .seq_en       (seq_en),
    .fetch_valid  (fetch_valid),
    .cache_hit    (cache_hit),
    .cache_data   (cache_data),
    .out_valid    (out_valid),
    .out_data     (out_data),
    .out_src      (out_src),
    .l2_req_valid (l2_req_valid),
    .l2_req_tag   (l2_req_tag),
    .ptr_q        (ptr_q),
    .gen_flat     (gen_flat)
);

// File: tb/tb_ibr_prefetch_ring.sv
// Scoreboard bench: tasks push expected L2 requests, a monitor pops and
// compares them; a fixed-latency L2 model answers every request.
module tb_ibr_prefetch_ring;
    localparam int NBUF  = 3;
    localparam int LINES = 2;
    localparam int AW    = 16;
    localparam int DW    = 32;
    localparam int GEN_W = 2;
    localparam int BW    = 2;
    localparam int SW    = 1;
    localparam int TAG_W = BW + SW + GEN_W;
    localparam int SRCW  = 2;
    localparam int LAT   = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic br_valid = 1'b0, seq_en = 1'b0, miss_valid = 1'b0;
    logic fetch_valid = 1'b0, cache_hit = 1'b0;
    logic [AW-1:0] br_target = '0, miss_addr = '0, fetch_addr = '0;
    logic [DW-1:0] cache_data = '0;
    logic out_valid, l2_req_valid, l2_rsp_valid;
    logic [DW-1:0] out_data, l2_rsp_data;
    logic [SRCW-1:0] out_src;
    logic [AW-1:0] l2_req_addr;
    logic [TAG_W-1:0] l2_req_tag, l2_rsp_tag;

    int checks = 0;
    int fails = 0;
    int bptr = 0;
    int bgen [NBUF];
    logic [AW+TAG_W-1:0] sbq [$];

    always #5 clk = ~clk;

    ibr_prefetch_ring #(.NBUF(NBUF), .LINES(LINES), .AW(AW), .DW(DW), .GEN_W(GEN_W)) dut (
        .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_target(br_target),
        .seq_en(seq_en), .miss_valid(miss_valid), .miss_addr(miss_addr),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .cache_hit(cache_hit), .cache_data(cache_data),
        .out_valid(out_valid), .out_data(out_data), .out_src(out_src),
        .l2_req_valid(l2_req_valid), .l2_req_addr(l2_req_addr), .l2_req_tag(l2_req_tag),
        .l2_rsp_valid(l2_rsp_valid), .l2_rsp_tag(l2_rsp_tag), .l2_rsp_data(l2_rsp_data)
    );

    function automatic logic [DW-1:0] line_of(input logic [AW-1:0] a);
        return {a ^ 16'h5A5A, a};
    endfunction

    // Fixed-latency L2 model.
    logic            pv [LAT];
    logic [AW-1:0]   pa [LAT];
    logic [TAG_W-1:0] pt [LAT];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LAT; i++) begin
                pv[i] <= 1'b0; pa[i] <= '0; pt[i] <= '0;
            end
        end else begin
            pv[0] <= l2_req_valid; pa[0] <= l2_req_addr; pt[0] <= l2_req_tag;
            for (int i = 1; i < LAT; i++) begin
                pv[i] <= pv[i-1]; pa[i] <= pa[i-1]; pt[i] <= pt[i-1];
            end
        end
    end
    assign l2_rsp_valid = pv[LAT-1];
    assign l2_rsp_tag   = pt[LAT-1];
    assign l2_rsp_data  = line_of(pa[LAT-1]);

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic exp_req(input logic [AW-1:0] a, input int b, input int s, input int g);
        sbq.push_back({a, BW'(b), SW'(s), GEN_W'(g)});
    endtask

    // Monitor: compare every raised request against the queue head (R3, R4).
    always @(negedge clk) begin
        if (rst_n && l2_req_valid) begin
            if (sbq.size() == 0) begin
                chk(1'b0, "R4 unexpected request", 64'({l2_req_addr, l2_req_tag}), 64'(0));
            end else begin
                logic [AW+TAG_W-1:0] e;
                e = sbq.pop_front();
                chk({l2_req_addr, l2_req_tag} == e, "R3/R4 request order",
                    64'({l2_req_addr, l2_req_tag}), 64'(e));
            end
        end
    end

    task automatic model_alloc(output int b, output int g);
        b = bptr;
        bgen[b]++;
        g = bgen[b] % (1 << GEN_W);
        bptr = (bptr + 1) % NBUF;
    endtask

    task automatic do_branch(input logic [AW-1:0] a, output int b, output int g);
        model_alloc(b, g);
        br_valid = 1'b1; br_target = a;
        @(negedge clk);
        br_valid = 1'b0;
    endtask

    task automatic do_miss(input logic [AW-1:0] a, output int b, output int g);
        b = -1; g = -1;
        if (seq_en) model_alloc(b, g);
        miss_valid = 1'b1; miss_addr = a;
        @(negedge clk);
        miss_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic look(input logic [AW-1:0] a, input bit ch, input logic [DW-1:0] cd,
                        output logic ov, output logic [DW-1:0] od, output logic [SRCW-1:0] os);
        fetch_valid = 1'b1; fetch_addr = a; cache_hit = ch; cache_data = cd;
        #1;
        ov = out_valid; od = out_data; os = out_src;
        fetch_valid = 1'b0; cache_hit = 1'b0;
    endtask

    task automatic expect_hit(input logic [AW-1:0] a, input int src, input string req);
        logic ov; logic [DW-1:0] od; logic [SRCW-1:0] os;
        look(a, 1'b0, '0, ov, od, os);
        chk(ov && od == line_of(a) && os == SRCW'(src), req,
            64'({ov, os, od}), 64'({1'b1, SRCW'(src), line_of(a)}));
    endtask

    task automatic expect_miss(input logic [AW-1:0] a, input string req);
        logic ov; logic [DW-1:0] od; logic [SRCW-1:0] os;
        look(a, 1'b0, '0, ov, od, os);
        chk(!ov, req, 64'(ov), 64'(0));
    endtask

    initial begin
        int b, g, b0, g0, b1, g1, b2, g2, b3, g3;
        logic ov; logic [DW-1:0] od; logic [SRCW-1:0] os;
        for (int i = 0; i < NBUF; i++) bgen[i] = 0;
        idle(5);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: idle after reset.
        chk(!l2_req_valid, "R1 no request after reset", 64'(l2_req_valid), 64'(0));
        expect_miss(16'h0000, "R1 empty buffers");

        // R1/R2/R3: first branch uses buffer 0 and requests both lines.
        exp_req(16'h0100, 0, 0, 1); exp_req(16'h0101, 0, 1, 1);
        do_branch(16'h0100, b, g);
        idle(14);
        expect_hit(16'h0100, 1, "R3 first line");
        expect_hit(16'h0101, 1, "R3 second line");

        // R5: pending lines report a miss.
        exp_req(16'h0200, 1, 0, 1); exp_req(16'h0201, 1, 1, 1);
        do_branch(16'h0200, b, g);
        expect_miss(16'h0200, "R5 waiting line");
        idle(2);
        expect_miss(16'h0200, "R5 pending line");
        idle(14);
        expect_hit(16'h0200, 2, "R6 buffer source code");

        // R6: cache has priority.
        look(16'h0200, 1'b1, 32'hCAFE_F00D, ov, od, os);
        chk(ov && os == 0 && od == 32'hCAFE_F00D, "R6 cache first",
            64'({ov, os, od}), 64'({1'b1, 2'd0, 32'hCAFE_F00D}));

        // R2/R4: back-to-back allocations issue oldest first.
        exp_req(16'h0300, 2, 0, 1); exp_req(16'h0301, 2, 1, 1);
        exp_req(16'h0400, 0, 0, 2); exp_req(16'h0401, 0, 1, 2);
        exp_req(16'h0500, 1, 0, 2); exp_req(16'h0501, 1, 1, 2);
        do_branch(16'h0300, b, g); do_branch(16'h0400, b, g); do_branch(16'h0500, b, g);
        idle(20);
        expect_miss(16'h0100, "R2 reallocated buffer dropped old line");
        expect_hit(16'h0300, 3, "R2 ring wrap buffer 2");
        expect_hit(16'h0401, 1, "R2 ring wrap buffer 0");

        // R7: youngest copy wins.
        exp_req(16'h0600, 2, 0, 2); exp_req(16'h0601, 2, 1, 2);
        exp_req(16'h0600, 0, 0, 3); exp_req(16'h0601, 0, 1, 3);
        do_branch(16'h0600, b, g); do_branch(16'h0600, b, g);
        idle(20);
        expect_hit(16'h0600, 1, "R7 youngest buffer");

        // R8: stale responses after reallocation are dropped.
        exp_req(16'h0700, 1, 0, 3); exp_req(16'h0701, 1, 1, 3);
        exp_req(16'h0710, 2, 0, 3); exp_req(16'h0711, 2, 1, 3);
        exp_req(16'h0720, 0, 0, 0); exp_req(16'h0721, 0, 1, 0);
        exp_req(16'h0730, 1, 0, 0); exp_req(16'h0731, 1, 1, 0);
        do_branch(16'h0700, b0, g0); do_branch(16'h0710, b1, g1);
        do_branch(16'h0720, b2, g2); do_branch(16'h0730, b3, g3);
        idle(7);
        expect_miss(16'h0730, "R8 stale response hidden");
        idle(14);
        expect_hit(16'h0730, 2, "R8 fresh response visible");
        expect_miss(16'h0700, "R8 old address gone");

        // R9: sequential mode on a miss.
        seq_en = 1'b1;
        exp_req(16'h0801, 2, 0, 0); exp_req(16'h0802, 2, 1, 0);
        do_miss(16'h0800, b, g);
        idle(14);
        expect_hit(16'h0801, 3, "R9 line after miss");
        expect_hit(16'h0802, 3, "R9 next sequential line");
        expect_miss(16'h0800, "R9 missing line not loaded");

        // R10: a branch stops the sequential fill.
        exp_req(16'h0901, 0, 0, 1);
        exp_req(16'h0A00, 1, 0, 1); exp_req(16'h0A01, 1, 1, 1);
        do_miss(16'h0900, b, g); do_branch(16'h0A00, b, g);
        idle(16);
        expect_hit(16'h0901, 1, "R10 issued line completes");
        expect_miss(16'h0902, "R10 branch cancelled line");

        // R10: a further miss stops the sequential fill.
        exp_req(16'h0B01, 2, 0, 1);
        exp_req(16'h0C01, 0, 0, 2); exp_req(16'h0C02, 0, 1, 2);
        do_miss(16'h0B00, b, g); do_miss(16'h0C00, b, g);
        idle(16);
        expect_miss(16'h0B02, "R10 miss cancelled line");
        expect_hit(16'h0C02, 1, "R10 new sequential fill");

        // R11: branch and miss together allocate once.
        exp_req(16'h0D00, 1, 0, 2); exp_req(16'h0D01, 1, 1, 2);
        model_alloc(b, g);
        br_valid = 1'b1; br_target = 16'h0D00; miss_valid = 1'b1; miss_addr = 16'h0E00;
        @(negedge clk);
        br_valid = 1'b0; miss_valid = 1'b0;
        exp_req(16'h0F00, 2, 0, 2); exp_req(16'h0F01, 2, 1, 2);
        do_branch(16'h0F00, b, g);
        idle(16);
        expect_miss(16'h0E01, "R11 miss ignored");
        expect_hit(16'h0F00, 3, "R11 pointer advanced once");

        // R9: a miss with sequential mode off allocates nothing.
        seq_en = 1'b0;
        do_miss(16'h1100, b, g);
        exp_req(16'h1200, 0, 0, 3); exp_req(16'h1201, 0, 1, 3);
        do_branch(16'h1200, b, g);
        idle(16);
        expect_miss(16'h1101, "R9 disabled miss ignored");
        expect_hit(16'h1200, 1, "R9 pointer unchanged");

        chk(sbq.size() == 0, "R4 all expected requests seen", 64'(sbq.size()), 64'(0));
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog.
    initial begin
        #1_000_000;
        checks++; fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule